// File: doc/BRIEF.md
# Code Flow Watchdog

This block watches the control flow of running software. Software opens a guarded region by writing a start value into a secure signature counter. That write also starts an instruction timer from a reload value. As the code runs, it moves the counter with add and subtract writes. These can carry an arbitrary operand, or be fixed steps of 1, 16 or 256 triggered by any write to the step register. At checkpoints, software writes the value it expects the counter to hold. A mismatch, a timer expiry or an operation issued in the wrong state sets a sticky fault flag. Each flag's action field then decides whether it raises an interrupt, requests a system reset, or does nothing.

The block sits on a simple single-cycle word bus. Writes take effect on the clock edge where `bus_wr` is sampled. Reads are combinational. The control register can be written only while the block is idle, and it can be locked. A persistent word survives the block's own soft reset. The asynchronous active-low reset is released synchronously through two flops.

Top module: `cfw_top`

## Requirements
- R1: After reset the block is idle. The control word reads 0. The flag word (address 4) reads 0x40: only the power-on bit 6 is set and the active bit 7 is clear. `irq_o` and `rst_req_o` are low.
- R2: A write to address 5 while idle loads the counter (readable at address 3) with the written value. It also loads the timer (readable at address 2) with the reload word (address 1) and sets the active bit 7.
- R3: While active, writes to address 8 or 12 add or subtract the operand. Any write to 9/10/11 adds 1/16/256, and any write to 13/14/15 subtracts 1/16/256, all modulo 2^32. A carry or borrow sets the counter flag, bit 3.
- R4: A write to address 6 while active returns the block to idle. If the written value differs from the counter, the miscompare flag (bit 1) is set.
- R5: A write to address 7 while active whose value matches the counter reloads the timer and keeps the block active. On a mismatch it sets bit 1 and leaves the timer counting.
- R6: A write to address 5 while active, or to any of addresses 6..15 while idle, is ignored and sets the sequence flag, bit 2.
- R7: While active, the timer falls by one on each unfrozen clock. An unfrozen clock that finds it at 0 sets the timeout flag (bit 0) and returns the block to idle. With reload R, the flag appears R+1 clocks after the start write.
- R8: The timer holds its value while control bit 10 and `irq_active_i` are both high, or while control bit 11 and `dbg_halted_i` are both high.
- R9: The control word (address 0) reads 0 while active. A control write while active is ignored and sets the state flag, bit 4.
- R10: Once control bit 12 (lock) is set, further control writes are ignored until a reset.
- R11: Flags stay set until software writes 1 to their bit at address 4. A bit written with 0 is left unchanged.
- R12: A bus access to an address above 17 sets the address flag, bit 5.
- R13: Each 2-bit action field works as follows: 01 asserts `irq_o` and 1x asserts `rst_req_o` while its flag is set. The fields are timeout [1:0], miscompare [3:2], sequence [5:4], state [7:6] and address [9:8]. Code 00 does nothing.
- R14: The word at address 16 reads back as written. A write to address 17 clears everything else, including the power-on flag, but leaves that word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not reading |
| irq_active_i | input | 1 | Processor is servicing an interrupt |
| dbg_halted_i | input | 1 | Processor is halted by a debugger |
| irq_o | output | 1 | Fault interrupt request |
| rst_req_o | output | 1 | Fault reset request |

## Verification
A write drives the bus for one clock edge. Its effect on the counter, timer, flags, control word and active bit is visible from the next clock on. The bench therefore samples at the falling edge that follows the writing edge, through a combinational read. The interrupt and reset outputs follow the flags with no added delay, so they are checked in the same half-cycle as the flag. Timer expiry is checked by counting clock edges from the start write: the flag must be absent after R edges and present after R+1.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  localparam int ADDR_W = 5;
  localparam int NFLAGS = 7;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD  = 5'd1;
  localparam logic [ADDR_W-1:0] A_TIMER   = 5'd2;
  localparam logic [ADDR_W-1:0] A_COUNT   = 5'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 5'd4;
  localparam logic [ADDR_W-1:0] A_START   = 5'd5;
  localparam logic [ADDR_W-1:0] A_STOP    = 5'd6;
  localparam logic [ADDR_W-1:0] A_RESTART = 5'd7;
  localparam logic [ADDR_W-1:0] A_ADD     = 5'd8;
  localparam logic [ADDR_W-1:0] A_ADD1    = 5'd9;
  localparam logic [ADDR_W-1:0] A_ADD16   = 5'd10;
  localparam logic [ADDR_W-1:0] A_ADD256  = 5'd11;
  localparam logic [ADDR_W-1:0] A_SUB     = 5'd12;
  localparam logic [ADDR_W-1:0] A_SUB1    = 5'd13;
  localparam logic [ADDR_W-1:0] A_SUB16   = 5'd14;
  localparam logic [ADDR_W-1:0] A_SUB256  = 5'd15;
  localparam logic [ADDR_W-1:0] A_KEEP    = 5'd16;
  localparam logic [ADDR_W-1:0] A_SOFTRST = 5'd17;

  localparam int F_TMO  = 0;
  localparam int F_MIS  = 1;
  localparam int F_SEQ  = 2;
  localparam int F_CNT  = 3;
  localparam int F_STA  = 4;
  localparam int F_ADR  = 5;
  localparam int F_POR  = 6;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_IRQ  = 2'b01,
    ACT_RST  = 2'b10,
    ACT_RST2 = 2'b11
  } act_e;

  typedef struct packed {
    logic       lock;
    logic       dbg_halt;
    logic       irq_pause;
    logic [1:0] adr_act;
    logic [1:0] sta_act;
    logic [1:0] seq_act;
    logic [1:0] mis_act;
    logic [1:0] tmo_act;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cfw_sec_counter.sv
module cfw_sec_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         upd_en,
  input  logic         upd_sub,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum_ext;

  always_comb begin
    if (upd_sub) sum_ext = {1'b0, cnt_q} - {1'b0, upd_val};
    else         sum_ext = {1'b0, cnt_q} + {1'b0, upd_val};
    cnt_d = cnt_q;
    if (soft_clr)    cnt_d = '0;
    else if (load)   cnt_d = load_val;
    else if (upd_en) cnt_d = sum_ext[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = upd_en & sum_ext[W];

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !upd_en && !soft_clr) |=> $stable(cnt_q));
  assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !soft_clr) |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/cfw_seq_fsm.sv
module cfw_seq_fsm #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          start,
  input  logic          stop,
  input  logic          restart,
  input  logic          freeze,
  input  logic [TW-1:0] reload,
  output logic          active_o,
  output logic [TW-1:0] timer_o,
  output logic          timeout_o
);
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_e;

  st_e          st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tick;

  assign tick      = (st_q == ST_RUN) && !freeze && !stop && !restart;
  assign timeout_o = tick && (tmr_q == '0) && !soft_clr;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    if (soft_clr) begin
      st_d  = ST_IDLE;
      tmr_d = '0;
    end else if (stop) begin
      st_d = ST_IDLE;
    end else if (start) begin
      st_d  = ST_RUN;
      tmr_d = reload;
    end else if (restart) begin
      tmr_d = reload;
    end else if (tick) begin
      if (tmr_q == '0) st_d  = ST_IDLE;
      else             tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign active_o = (st_q == ST_RUN);
  assign timer_o  = tmr_q;

  assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !active_o);
  assert_timer_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && freeze && !stop && !restart && !soft_clr) |=> $stable(tmr_q));
  assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !active_o);
endmodule

// File: rtl/cfw_fault.sv
module cfw_fault #(
  parameter int N = 7,
  parameter int POR_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic [N-1:0]     set_i,
  input  logic [N-1:0]     clr_i,
  input  logic [N-1:0][1:0] act_i,
  output logic [N-1:0]     flags_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam logic [N-1:0] RST_VAL = N'(1) << POR_BIT;

  logic [N-1:0] flg_q, flg_d;
  logic [N-1:0] irq_src, rst_src;

  always_comb begin
    if (soft_clr) flg_d = '0;
    else          flg_d = (flg_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= RST_VAL;
    else        flg_q <= flg_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    assign irq_src[i] = flg_q[i] && (act_i[i] == 2'b01);
    assign rst_src[i] = flg_q[i] && act_i[i][1];
  end

  assign flags_o   = flg_q;
  assign irq_o     = |irq_src;
  assign rst_req_o = |rst_src;

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> ((flg_q & $past(flg_q & ~clr_i)) == $past(flg_q & ~clr_i)));
  assert_set_seen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> ((flg_q & $past(set_i)) == $past(set_i)));
  assert_irq_needs_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flg_q != '0));
endmodule

// File: rtl/cfw_top.sv
module cfw_top
  import cfw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TIMER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_active_i,
  input  logic              dbg_halted_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam logic [DATA_W-1:0] STEP1   = DATA_W'(1);
  localparam logic [DATA_W-1:0] STEP16  = DATA_W'(16);
  localparam logic [DATA_W-1:0] STEP256 = DATA_W'(256);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // address decode
  logic mapped, is_upd, wr_hit_ctrl;
  logic active, match, soft_clr;
  logic start_ok, stop_ok, restart_ok, restart_bad;
  logic seq_err, mis_err, sta_err, adr_err, freeze, timeout, wrap;
  logic upd_en, upd_sub;
  logic [DATA_W-1:0] upd_val, cnt;
  logic [TIMER_W-1:0] timer;
  logic [NFLAGS-1:0] flags, set_vec, clr_vec;
  logic [NFLAGS-1:0][1:0] act_vec;

  ctrl_t ctrl_q, ctrl_d;
  logic [TIMER_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0]  keep_q, keep_d;

  assign mapped   = (bus_addr <= A_SOFTRST);
  assign is_upd   = (bus_addr >= A_ADD) && (bus_addr <= A_SUB256);
  assign soft_clr = bus_wr && (bus_addr == A_SOFTRST);
  assign match    = (bus_wdata == cnt);

  assign start_ok    = bus_wr && (bus_addr == A_START)   && !active;
  assign stop_ok     = bus_wr && (bus_addr == A_STOP)    && active;
  assign restart_ok  = bus_wr && (bus_addr == A_RESTART) && active && match;
  assign restart_bad = bus_wr && (bus_addr == A_RESTART) && active && !match;
  assign seq_err     = bus_wr && (((bus_addr == A_START) && active) ||
                       (((bus_addr == A_STOP) || (bus_addr == A_RESTART) || is_upd) && !active));
  assign mis_err     = (stop_ok && !match) || restart_bad;
  assign wr_hit_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign sta_err     = wr_hit_ctrl && active;
  assign adr_err     = (bus_wr || bus_rd) && !mapped;
  assign freeze      = (ctrl_q.irq_pause && irq_active_i) || (ctrl_q.dbg_halt && dbg_halted_i);

  always_comb begin
    upd_en  = bus_wr && is_upd && active;
    upd_sub = (bus_addr >= A_SUB);
    unique case (bus_addr)
      A_ADD1, A_SUB1:     upd_val = STEP1;
      A_ADD16, A_SUB16:   upd_val = STEP16;
      A_ADD256, A_SUB256: upd_val = STEP256;
      default:            upd_val = bus_wdata;
    endcase
  end

  // configuration registers: next state
  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    keep_d   = keep_q;
    if (soft_clr) begin
      ctrl_d   = '0;
      reload_d = '0;
    end else if (bus_wr) begin
      if (wr_hit_ctrl && !active && !ctrl_q.lock) ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (bus_addr == A_RELOAD) reload_d = bus_wdata[TIMER_W-1:0];
      if (bus_addr == A_KEEP)   keep_d   = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      keep_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      keep_q   <= keep_d;
    end
  end

  cfw_sec_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .soft_clr(soft_clr),
    .load(start_ok), .load_val(bus_wdata),
    .upd_en(upd_en), .upd_sub(upd_sub), .upd_val(upd_val),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  cfw_seq_fsm #(.TW(TIMER_W)) u_fsm (
    .clk(clk), .rst_n(rst_ni), .soft_clr(soft_clr),
    .start(start_ok), .stop(stop_ok), .restart(restart_ok),
    .freeze(freeze), .reload(reload_q),
    .active_o(active), .timer_o(timer), .timeout_o(timeout)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[F_TMO] = timeout;
    set_vec[F_MIS] = mis_err;
    set_vec[F_SEQ] = seq_err;
    set_vec[F_CNT] = wrap;
    set_vec[F_STA] = sta_err;
    set_vec[F_ADR] = adr_err;
    clr_vec        = (bus_wr && (bus_addr == A_FLAGS)) ? bus_wdata[NFLAGS-1:0] : '0;
    act_vec        = '0;
    act_vec[F_TMO] = ctrl_q.tmo_act;
    act_vec[F_MIS] = ctrl_q.mis_act;
    act_vec[F_SEQ] = ctrl_q.seq_act;
    act_vec[F_STA] = ctrl_q.sta_act;
    act_vec[F_ADR] = ctrl_q.adr_act;
  end

  cfw_fault #(.N(NFLAGS), .POR_BIT(F_POR)) u_flt (
    .clk(clk), .rst_n(rst_ni), .soft_clr(soft_clr),
    .set_i(set_vec), .clr_i(clr_vec), .act_i(act_vec),
    .flags_o(flags), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL:   bus_rdata = active ? '0 : DATA_W'(ctrl_q);
        A_RELOAD: bus_rdata = DATA_W'(reload_q);
        A_TIMER:  bus_rdata = DATA_W'(timer);
        A_COUNT:  bus_rdata = cnt;
        A_FLAGS:  bus_rdata = DATA_W'({active, flags});
        A_KEEP:   bus_rdata = keep_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assert_ctrl_busy_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_hit_ctrl && active) |=> ($stable(ctrl_q) && flags[F_STA]));
  assert_ctrl_lock_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q.lock && !soft_clr) |=> $stable(ctrl_q));
  assert_addr_fault_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && !mapped) |=> flags[F_ADR]);
  assert_keep_soft_R14: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_clr |=> $stable(keep_q));
  assert_seq_ignored_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && (bus_addr == A_START) && active) |=> (active && flags[F_SEQ]));
endmodule

// File: tb/sim_cfw_top.sv
module sim_cfw_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_active_i = 1'b0, dbg_halted_i = 1'b0;
  logic        irq_o, rst_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfw_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_active_i(irq_active_i), .dbg_halted_i(dbg_halted_i),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the following falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic logic [31:0] f_step(input int op, input logic [31:0] v);
    case (op)
      1, 5: return 32'd1;
      2, 6: return 32'd16;
      3, 7: return 32'd256;
      default: return v;
    endcase
  endfunction

  function automatic logic [32:0] f_apply(input int op, input logic [31:0] c, input logic [31:0] s);
    if (op >= 4) return {1'b0, c} - {1'b0, s};
    return {1'b0, c} + {1'b0, s};
  endfunction

  logic [31:0] r, cm, v, s;
  logic [32:0] e;
  logic [7:0]  fm;

  initial begin
    void'($urandom(32'd20240611));
    #(3*CLK_PERIOD + 2) rst_n = 1'b1;
    cyc(3);
    @(negedge clk);

    // R1: reset state
    rd(5'd4, r); chk("R1 flags", r, 32'h40);
    rd(5'd0, r); chk("R1 ctrl", r, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req_o}, 32'd0);
    wr(5'd4, 32'h7F);
    rd(5'd4, r); chk("R11 w1c clears por", r, 32'h0);

    // R2/R3/R5: random counter updates
    wr(5'd1, 32'h0000_FFFF);
    cm = $urandom;
    wr(5'd5, cm);
    rd(5'd3, r); chk("R2 counter loaded", r, cm);
    rd(5'd2, r); chk("R2 timer loaded", r, 32'h0000_FFFF);
    rd(5'd4, r); chk("R2 active", r, 32'h80);
    fm = 8'h80;
    for (int k = 0; k < 80; k++) begin
      int op;
      op = int'($urandom_range(0, 8));
      v  = (k % 3 == 0) ? $urandom : $urandom_range(0, 300);
      if (op == 8) begin
        wr(5'd7, cm);
        rd(5'd2, r); chk("R5 restart reload", r, 32'h0000_FFFF);
      end else begin
        s = f_step(op, v);
        e = f_apply(op, cm, s);
        wr(5'(8 + op), v);
        cm = e[31:0];
        if (e[32]) fm[3] = 1'b1;
        rd(5'd3, r); chk("R3 counter value", r, cm);
      end
      rd(5'd4, r); chk("R3 counter flag", r, {24'd0, fm});
    end
    wr(5'd4, 32'h7F);

    // R4: stop with match and mismatch
    wr(5'd6, cm);
    rd(5'd4, r); chk("R4 stop match idle", r, 32'h0);
    wr(5'd5, 32'd100);
    wr(5'd6, 32'd99);
    rd(5'd4, r); chk("R4 stop mismatch", r, 32'h02);
    wr(5'd4, 32'h7F);

    // R5: restart mismatch keeps counting
    wr(5'd1, 32'd40);
    wr(5'd5, 32'd7);
    wr(5'd7, 32'd8);
    rd(5'd4, r); chk("R5 restart mismatch flag", r, 32'h82);
    rd(5'd2, r); chk("R5 timer not reloaded", r, 32'd39);

    // R6: start while active is ignored
    wr(5'd5, 32'd55);
    rd(5'd3, r); chk("R6 start ignored", r, 32'd7);
    rd(5'd4, r); chk("R6 seq flag active", r, 32'h86);
    wr(5'd6, 32'd7);
    wr(5'd4, 32'h7F);
    wr(5'd9, 32'd0);
    rd(5'd4, r); chk("R6 add while idle", r, 32'h04);
    rd(5'd3, r); chk("R6 counter untouched", r, 32'd7);
    wr(5'd4, 32'h7F);

    // R7: timeout timing
    wr(5'd1, 32'd5);
    wr(5'd5, 32'd1);
    rd(5'd2, r); chk("R7 timer start", r, 32'd5);
    cyc(5);
    rd(5'd4, r); chk("R7 no timeout yet", r, 32'h80);
    cyc(1);
    rd(5'd4, r); chk("R7 timeout idle", r, 32'h01);
    wr(5'd4, 32'h7F);

    // R8: freeze by interrupt pause and debug halt
    wr(5'd0, 32'h0000_0C00);
    wr(5'd1, 32'd10);
    wr(5'd5, 32'd3);
    irq_active_i = 1'b1;
    cyc(3);
    rd(5'd2, r); chk("R8 irq freeze", r, 32'd10);
    irq_active_i = 1'b0;
    cyc(1);
    rd(5'd2, r); chk("R8 resumes", r, 32'd9);
    dbg_halted_i = 1'b1;
    cyc(2);
    rd(5'd2, r); chk("R8 debug freeze", r, 32'd9);
    dbg_halted_i = 1'b0;

    // R9: control while active
    rd(5'd0, r); chk("R9 ctrl reads 0 active", r, 32'h0);
    wr(5'd0, 32'h3);
    rd(5'd4, r); chk("R9 state flag", r, 32'h90);
    wr(5'd6, 32'd3);
    rd(5'd0, r); chk("R9 ctrl unchanged", r, 32'h0C00);
    wr(5'd4, 32'h7F);

    // R13: actions
    wr(5'd0, 32'h0000_0021);
    wr(5'd1, 32'd2);
    wr(5'd5, 32'd0);
    cyc(3);
    chk("R13 irq on timeout", {30'd0, irq_o, rst_req_o}, 32'h2);
    wr(5'd4, 32'h01);
    chk("R13 irq cleared", {30'd0, irq_o, rst_req_o}, 32'h0);
    wr(5'd6, 32'd0);
    chk("R13 reset req on seq", {30'd0, irq_o, rst_req_o}, 32'h1);
    wr(5'd4, 32'h7F);

    // R12 / R11
    wr(5'd20, 32'hDEAD);
    rd(5'd4, r); chk("R12 address flag", r, 32'h20);
    wr(5'd31, 32'h0);
    wr(5'd4, 32'h01);
    rd(5'd4, r); chk("R11 other bit kept", r, 32'h20);
    wr(5'd4, 32'h20);
    rd(5'd4, r); chk("R11 cleared", r, 32'h0);

    // R10: lock
    wr(5'd0, 32'h0000_1005);
    wr(5'd0, 32'h0);
    rd(5'd0, r); chk("R10 locked", r, 32'h1005);

    // R14: persistent word and soft reset
    wr(5'd16, 32'hA5A5_1234);
    rd(5'd16, r); chk("R14 readback", r, 32'hA5A5_1234);
    wr(5'd17, 32'h0);
    rd(5'd16, r); chk("R14 kept after soft reset", r, 32'hA5A5_1234);
    rd(5'd0, r); chk("R14 ctrl cleared", r, 32'h0);
    rd(5'd4, r); chk("R14 flags cleared", r, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule